// File: doc/BRIEF.md
# Addressed Serial Channel Register Bank

This block is the receiving end of a three-wire serial link that sets twelve 8-bit output registers. A host shifts a 12-bit word in on a data line, one bit per rising edge of a shift clock, and then raises a load strobe. On that strobe, the 4-bit channel select in the word picks one register, and the word's 8-bit value is written into it. The registers drive external converters, which are not part of this block.

The bit that leaves the far end of the shift register appears on a serial output. Several devices can therefore be chained, each one passing the host's bits on to the next. All three link inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser. The block acts on the rising edges of the shift clock and the strobe as seen in the system clock domain, so a strobe held high writes only once.

Word layout: bits are sent D0 first and D11 last. D0..D7 form the channel value, with D0 as its least significant bit. D8..D11 form the select code, with D8 as its most significant bit.

Top module: `serial_chan_bank`

## Requirements
- R1: After reset every channel register reads 0 and the serial output is low.
- R2: The shift register advances only on a rising edge of the synchronised shift clock. Changes on the data line with no shift clock edge leave its content unchanged.
- R3: Only a rising edge of the synchronised load strobe writes a channel. A strobe held high over later shifting writes nothing more until it falls and rises again.
- R4: Select codes 1 to 12 (D8 = MSB of the code) write channels 1 to 12 in that order. The value written is D0..D7 with D0 as the LSB.
- R5: Select codes 0, 13, 14 and 15 change no channel register.
- R6: The serial output carries the oldest bit held in the shift register. While a second word is shifted in, the output presents the first word's bits D0 through D11 in order.
- R7: A channel register changes on the third system clock rising edge after the strobe input rises, and not before. The serial output changes on the third edge after the shift clock input rises.
- R8: A write leaves every channel other than the selected one unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdat_in | input | 1 | Serial data, asynchronous |
| load_in | input | 1 | Load strobe, asynchronous |
| sdo | output | 1 | Cascade serial output (oldest shifted bit) |
| chan_flat | output | 96 | Channel registers, channel n at bits [8n-1:8n-8] |

## Verification
Each input passes through two synchroniser flops and one edge-detect stage. A shift or a write therefore lands on the third rising system clock edge after the input changes. The bench drives inputs at a falling edge. In the latency test it samples at the falling edges after the second and the third rising edges, and it expects the old value at the first of these and the new value at the second. In every other scenario the serial lines move slowly: each level is held for several system cycles, and the bench samples only once the three-edge delay has elapsed.

// File: rtl/serial_chan_bank.sv
module serial_chan_bank #(
  parameter int CH = 12,
  parameter int DW = 8,
  parameter int SW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_in,
  input  logic           sdat_in,
  input  logic           load_in,
  output logic           sdo,
  output logic [CH*DW-1:0] chan_flat
);
  localparam int WL = DW + SW;

  logic [2:0]    ck_q, ld_q;
  logic [1:0]    dt_q;
  logic [WL-1:0] sr;
  logic          shift_ev, load_ev;
  logic [SW-1:0] sel;
  logic [DW-1:0] val;
  logic [DW-1:0] ch_q [CH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      ld_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[1:0], sclk_in};
      ld_q <= {ld_q[1:0], load_in};
      dt_q <= {dt_q[0], sdat_in};
    end

  assign shift_ev = ck_q[1] & ~ck_q[2];
  assign load_ev  = ld_q[1] & ~ld_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (shift_ev) sr <= {sr[WL-2:0], dt_q[1]};

  assign sdo = sr[WL-1];
  assign sel = sr[SW-1:0];

  for (genvar i = 0; i < DW; i++) begin : g_val
    assign val[i] = sr[WL-1-i];
  end

  for (genvar g = 0; g < CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                ch_q[g] <= '0;
      else if (load_ev && sel == SW'(g + 1))     ch_q[g] <= val;

    assign chan_flat[g*DW +: DW] = ch_q[g];

    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (load_ev && sel == SW'(g + 1)) |=> ch_q[g] == $past(val)); // R4
    AST_OTHERS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_ev && sel == SW'(g + 1)) |=> $stable(ch_q[g])); // R8
  end

  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev |=> $stable(sr)); // R2
  AST_SDO_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> sdo == $past(sr[WL-2])); // R6
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && (sel == '0 || sel > SW'(CH))) |=> $stable(chan_flat)); // R5
  AST_NO_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(chan_flat)); // R3
endmodule

// File: tb/tb_serial_chan_bank.sv
module tb_serial_chan_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 12;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0, sclk_in = 0, sdat_in = 0, load_in = 0;
  logic sdo;
  logic [CH*DW-1:0] chan_flat;
  logic [DW-1:0] exp_ch [CH];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  serial_chan_bank dut (.clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
                        .load_in(load_in), .sdo(sdo), .chan_flat(chan_flat));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < CH; c++) chk(req, chan_flat[c*DW +: DW], exp_ch[c]);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); sdat_in = b;
    wait_neg(3); sclk_in = 1;
    wait_neg(4); sclk_in = 0;
    wait_neg(4);
  endtask

  function automatic bit [11:0] mk_word(int sel, int val);
    bit [11:0] w;
    for (int i = 0; i < 8; i++) w[i] = val[i];
    for (int i = 0; i < 4; i++) w[8 + i] = sel[3 - i];
    return w;
  endfunction

  task automatic send_word(int sel, int val);
    bit [11:0] w = mk_word(sel, val);
    for (int i = 0; i < 12; i++) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk); load_in = 1;
    wait_neg(5); load_in = 0;
    wait_neg(4);
  endtask

  task automatic t_reset();
    chk_all("R1");
    chk("R1", sdo, 0);
  endtask

  task automatic t_write_all();
    for (int c = 1; c <= CH; c++) begin
      int v = (c * 37 + 5) & 8'hFF;
      send_word(c, v);
      pulse_load();
      exp_ch[c-1] = v[7:0];
      chk_all("R4/R8");
    end
  endtask

  task automatic t_bad_codes();
    int codes[4] = '{0, 13, 14, 15};
    foreach (codes[k]) begin
      send_word(codes[k], 8'hA5);
      pulse_load();
      chk_all("R5");
    end
  endtask

  task automatic t_no_clock_no_shift();
    send_word(3, 8'h81);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sdat_in = ~sdat_in;
      wait_neg(3);
    end
    chk("R2", sdo, 1);
    pulse_load();
    exp_ch[2] = 8'h81;
    chk_all("R2");
  endtask

  task automatic t_latency();
    send_word(5, 8'h3C);
    @(negedge clk); load_in = 1;
    wait_neg(2);
    chk("R7", chan_flat[4*DW +: DW], exp_ch[4]);
    wait_neg(1);
    chk("R7", chan_flat[4*DW +: DW], 8'h3C);
    exp_ch[4] = 8'h3C;
    wait_neg(3); load_in = 0; wait_neg(4);
    send_word(1, 8'h01);
    @(negedge clk); sdat_in = 0;
    wait_neg(3);
    @(negedge clk); sclk_in = 1;
    wait_neg(2);
    chk("R7", sdo, 1);
    wait_neg(1);
    chk("R7", sdo, 0);
    sclk_in = 0; wait_neg(4);
  endtask

  task automatic t_long_strobe();
    send_word(2, 8'h5A);
    @(negedge clk); load_in = 1;
    wait_neg(5);
    exp_ch[1] = 8'h5A;
    chk_all("R3");
    send_word(2, 8'hC3);
    wait_neg(5);
    chk_all("R3");
    load_in = 0; wait_neg(4);
    pulse_load();
    exp_ch[1] = 8'hC3;
    chk_all("R3");
  endtask

  task automatic t_cascade();
    bit [11:0] a = mk_word(7, 8'h96);
    bit [11:0] b = mk_word(9, 8'h4E);
    send_word(7, 8'h96);
    for (int i = 0; i < 12; i++) begin
      chk("R6", sdo, a[i]);
      send_bit(b[i]);
    end
    chk("R6", sdo, b[0]);
    pulse_load();
    exp_ch[8] = 8'h4E;
    chk_all("R6");
  endtask

  initial begin
    for (int c = 0; c < CH; c++) exp_ch[c] = '0;
    wait_neg(3);
    t_reset();
    rst_n = 1;
    wait_neg(2);
    t_reset();
    t_write_all();
    t_bad_codes();
    t_no_clock_no_shift();
    t_latency();
    t_long_strobe();
    t_cascade();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule